// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler with Barrier Synchronisation

This block decides which warp of a SIMT core issues on each clock. For every warp it holds an active flag, a stall flag, one program counter shared by all of the warp's threads, and a thread-enable mask that says which threads write back. On each cycle it offers one ready warp: its id, its PC and its thread mask. A warp is ready when it is active and not stalled. The offered warp's PC then moves forward by one instruction.

Decode feeds the block in two ways. A hold strobe stalls a warp that has just been found to carry a warp-control instruction. A command port then applies the effect of that instruction. There are three commands. The first sets the warp's thread mask from a count. The second starts a group of warps at a common address. The third is an arrival at a counted barrier, which keeps warps parked until enough of them have arrived. Branch outcomes enter through a separate PC-redirect port. A done output rises once no warp is active.

Top module: `warp_sched`

## Requirements
- R1: After reset only warp 0 is active and no warp is stalled. Every warp's PC equals `RESET_PC` and every thread mask is 1 (thread 0 only). The first offer is warp 0 at `RESET_PC` with `done` low.
- R2: `issue_valid` is high exactly when at least one warp is both active and not stalled. An offered warp is always such a warp.
- R3: The offered warp is the first ready warp found by scanning upward from the warp after the last one offered, wrapping past the highest id to warp 0. After reset the scan starts at warp 0.
- R4: The PC of the offered warp is higher by `INSTR_BYTES` on the following cycle. When `redir_valid` names a warp, that warp's PC takes `redir_pc` instead, and the redirect wins over the advance.
- R5: `hold_valid` sets the stall flag of `hold_wid` for the next cycle. A thread-mask or spawn command (`ctl_op` 1 or 2) clears the stall flag of `ctl_wid`. `ctl_op` 0 does nothing.
- R6: The thread-mask command (`ctl_op`=1) with count c sets the mask of `ctl_wid` to its lowest c threads, saturating at all threads. A count of 0 instead deactivates the warp and leaves its mask unchanged.
- R7: The spawn command (`ctl_op`=2) with count c affects every warp whose id is below min(c, `NUM_WARPS`), except `ctl_wid`. Each such warp becomes active and unstalled, with PC `ctl_addr` and thread mask 1. Other warps keep their state, and so does `ctl_wid` apart from the stall flag.
- R8: The barrier command (`ctl_op`=3) with id b and count c stalls `ctl_wid` and records it at barrier b. The arrival that brings the number of arrivals at b to at least c releases every recorded warp and the arriving warp in the same cycle, and empties the barrier. A count of 0 or 1 releases at once. Each barrier id counts on its own.
- R9: `done` is high exactly when no warp is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_valid | input | 1 | Stall the warp named by hold_wid |
| hold_wid | input | WID_W | Warp to stall |
| ctl_op | input | 2 | Command: 0 none, 1 thread mask, 2 spawn, 3 barrier |
| ctl_wid | input | WID_W | Warp that executed the command |
| ctl_count | input | CNT_W | Thread, warp or arrival count |
| ctl_addr | input | PC_W | Start address for spawned warps |
| ctl_bar | input | BAR_W | Barrier id |
| redir_valid | input | 1 | Overwrite a warp's PC |
| redir_wid | input | WID_W | Warp to redirect |
| redir_pc | input | PC_W | New PC |
| issue_valid | output | 1 | A warp is offered this cycle |
| issue_wid | output | WID_W | Offered warp id |
| issue_pc | output | PC_W | Offered warp's PC |
| issue_tmask | output | NUM_THREADS | Offered warp's thread mask |
| done | output | 1 | No warp is active |

## Verification
The bench sweeps every non-empty pattern of ready warps among four active warps. It holds each pattern for several cycles, so wrap-around and skipping of stalled warps show up as differences from a plain modulo counter. Thread-mask counts of 0, mid-range and above the thread count separate deactivation, truncation and saturation. Spawn counts both below and at the warp count, issued from a non-zero warp, show whether warps outside the range and the issuing warp are left alone. Barrier arrivals are interleaved across two ids with counts 0, 2 and 3, which shows whether release waits for its own id's count and frees every member together.

// File: rtl/warp_sched_pkg.sv
`timescale 1ns/1ps
package warp_sched_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_TMC   = 2'd1,
      OP_SPAWN = 2'd2,
      OP_BAR   = 2'd3
   } wctl_op_e;
endpackage

// File: rtl/warp_sched_lowmask.sv
`timescale 1ns/1ps
// Thermometer mask: bit i set when i < count (saturates naturally)
module warp_sched_lowmask #(
   parameter int N     = 4,
   parameter int CNT_W = 4
) (
   input  logic [CNT_W-1:0] count,
   output logic [N-1:0]     mask
);
   generate
      if ((1 << CNT_W) <= N - 1) begin : g_bad
         $error("warp_sched_lowmask: CNT_W too narrow for N");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign mask[i] = (CNT_W'(i) < count);
      end
   endgenerate
endmodule

// File: rtl/warp_sched_rr.sv
`timescale 1ns/1ps
// Round-robin picker: first ready warp at or after ptr, wrapping
module warp_sched_rr #(
   parameter int NW = 4,
   localparam int WW = $clog2(NW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NW-1:0] ready,
   input  logic [WW-1:0] ptr,
   output logic          valid,
   output logic [WW-1:0] wid
);
   always_comb begin
      valid = 1'b0;
      wid   = '0;
      for (int i = NW - 1; i >= 0; i--) begin
         logic [WW:0] sum;
         sum = {1'b0, ptr} + (WW + 1)'(i);
         if (sum >= (WW + 1)'(NW)) sum = sum - (WW + 1)'(NW);
         if (ready[sum[WW-1:0]]) begin
            valid = 1'b1;
            wid   = sum[WW-1:0];
         end
      end
   end

   AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ready[wid]);                                          // R3
   AST_PICK_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (ready != '0) |-> valid);                                       // R2
endmodule

// File: rtl/warp_sched_bar.sv
`timescale 1ns/1ps
// Counted barrier table: one member set and arrival count per id
module warp_sched_bar #(
   parameter int NW    = 4,
   parameter int NB    = 2,
   parameter int CNT_W = 4,
   localparam int WW   = $clog2(NW),
   localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arr_valid,
   input  logic [BW-1:0]    arr_id,
   input  logic [WW-1:0]    arr_wid,
   input  logic [CNT_W-1:0] arr_count,
   output logic [NW-1:0]    rel_mask
);
   logic [NW-1:0] arr_bit;
   logic [NW-1:0] rel_each [NB];

   assign arr_bit = NW'(1) << arr_wid;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bar
         logic [NW-1:0]    members;
         logic [CNT_W-1:0] cnt;
         logic             here;
         logic             hit;

         assign here = arr_valid && (arr_id == BW'(b));
         assign hit  = here && ((cnt + CNT_W'(1)) >= arr_count);
         assign rel_each[b] = hit ? (members | arr_bit) : '0;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               members <= '0;
               cnt     <= '0;
            end else if (hit) begin
               members <= '0;
               cnt     <= '0;
            end else if (here) begin
               members <= members | arr_bit;
               cnt     <= cnt + CNT_W'(1);
            end
         end

         AST_BAR_POP: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(members) == 32'(cnt));                         // R8
      end
   endgenerate

   always_comb begin
      rel_mask = '0;
      for (int b = 0; b < NB; b++) rel_mask = rel_mask | rel_each[b];
   end
endmodule

// File: rtl/warp_sched.sv
`timescale 1ns/1ps
module warp_sched
   import warp_sched_pkg::*;
#(
   parameter int          NUM_WARPS    = 4,
   parameter int          NUM_THREADS  = 4,
   parameter int          NUM_BARRIERS = 2,
   parameter int          PC_W         = 32,
   parameter int          CNT_W        = 4,
   parameter int          INSTR_BYTES  = 4,
   parameter logic [31:0] RESET_PC     = 32'h8000_0000,
   localparam int WID_W = $clog2(NUM_WARPS),
   localparam int BAR_W = (NUM_BARRIERS > 1) ? $clog2(NUM_BARRIERS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hold_valid,
   input  logic [WID_W-1:0]       hold_wid,
   input  logic [1:0]             ctl_op,
   input  logic [WID_W-1:0]       ctl_wid,
   input  logic [CNT_W-1:0]       ctl_count,
   input  logic [PC_W-1:0]        ctl_addr,
   input  logic [BAR_W-1:0]       ctl_bar,
   input  logic                   redir_valid,
   input  logic [WID_W-1:0]       redir_wid,
   input  logic [PC_W-1:0]        redir_pc,
   output logic                   issue_valid,
   output logic [WID_W-1:0]       issue_wid,
   output logic [PC_W-1:0]        issue_pc,
   output logic [NUM_THREADS-1:0] issue_tmask,
   output logic                   done
);
   localparam int NW = NUM_WARPS;
   localparam int NT = NUM_THREADS;
   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);
   localparam logic [PC_W-1:0] PC0  = PC_W'(RESET_PC);

   generate
      if (NW < 2)            begin : g_e0 $error("NUM_WARPS must be >= 2"); end
      if (NT < 1)            begin : g_e1 $error("NUM_THREADS must be >= 1"); end
      if (NUM_BARRIERS < 1)  begin : g_e2 $error("NUM_BARRIERS must be >= 1"); end
      if ((1 << CNT_W) <= NW || (1 << CNT_W) <= NT)
                             begin : g_e3 $error("CNT_W too narrow"); end
   endgenerate

   wctl_op_e op;
   assign op = wctl_op_e'(ctl_op);

   // per-warp state
   logic [NW-1:0]   active, stall;
   logic [PC_W-1:0] pc    [NW];
   logic [NT-1:0]   tmask [NW];
   logic [WID_W-1:0] ptr;

   logic [NW-1:0]   active_n, stall_n;
   logic [PC_W-1:0] pc_n    [NW];
   logic [NT-1:0]   tmask_n [NW];
   logic [WID_W-1:0] ptr_n;

   logic [NW-1:0] ready;
   assign ready = active & ~stall;

   // issue selection
   warp_sched_rr #(.NW(NW)) u_rr (
      .clk(clk), .rst_n(rst_n), .ready(ready), .ptr(ptr),
      .valid(issue_valid), .wid(issue_wid)
   );

   assign issue_pc    = pc[issue_wid];
   assign issue_tmask = tmask[issue_wid];
   assign done        = (active == '0);

   // command decoders
   logic [NT-1:0] tmc_mask;
   logic [NW-1:0] spawn_range, spawn_sel, ctl_bit, rel_mask;

   warp_sched_lowmask #(.N(NT), .CNT_W(CNT_W)) u_tmc_mask (
      .count(ctl_count), .mask(tmc_mask)
   );
   warp_sched_lowmask #(.N(NW), .CNT_W(CNT_W)) u_spawn_mask (
      .count(ctl_count), .mask(spawn_range)
   );

   assign ctl_bit   = NW'(1) << ctl_wid;
   assign spawn_sel = (op == OP_SPAWN) ? (spawn_range & ~ctl_bit) : '0;

   warp_sched_bar #(.NW(NW), .NB(NUM_BARRIERS), .CNT_W(CNT_W)) u_bar (
      .clk(clk), .rst_n(rst_n),
      .arr_valid(op == OP_BAR), .arr_id(ctl_bar),
      .arr_wid(ctl_wid), .arr_count(ctl_count),
      .rel_mask(rel_mask)
   );

   // next-state: advance, redirect, commands, release, hold (later wins)
   always_comb begin
      active_n = active;
      stall_n  = stall;
      for (int w = 0; w < NW; w++) begin
         pc_n[w]    = pc[w];
         tmask_n[w] = tmask[w];
      end
      ptr_n = ptr;

      if (issue_valid) begin
         pc_n[issue_wid] = pc[issue_wid] + STEP;
         ptr_n = (issue_wid == WID_W'(NW - 1)) ? '0 : issue_wid + WID_W'(1);
      end
      if (redir_valid) pc_n[redir_wid] = redir_pc;

      case (op)
         OP_TMC: begin
            if (ctl_count == '0) active_n[ctl_wid] = 1'b0;
            else                 tmask_n[ctl_wid]  = tmc_mask;
            stall_n[ctl_wid] = 1'b0;
         end
         OP_SPAWN: begin
            for (int w = 0; w < NW; w++) begin
               if (spawn_sel[w]) begin
                  active_n[w] = 1'b1;
                  stall_n[w]  = 1'b0;
                  pc_n[w]     = ctl_addr;
                  tmask_n[w]  = NT'(1);
               end
            end
            stall_n[ctl_wid] = 1'b0;
         end
         OP_BAR:  stall_n[ctl_wid] = 1'b1;
         default: ;
      endcase

      stall_n = stall_n & ~rel_mask;
      if (hold_valid) stall_n[hold_wid] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= NW'(1);
         stall  <= '0;
         ptr    <= '0;
         for (int w = 0; w < NW; w++) begin
            pc[w]    <= PC0;
            tmask[w] <= NT'(1);
         end
      end else begin
         active <= active_n;
         stall  <= stall_n;
         ptr    <= ptr_n;
         for (int w = 0; w < NW; w++) begin
            pc[w]    <= pc_n[w];
            tmask[w] <= tmask_n[w];
         end
      end
   end

   // checker state for PC advance
   logic             chk_v;
   logic [WID_W-1:0] chk_wid;
   logic [PC_W-1:0]  chk_pc;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_v   <= 1'b0;
         chk_wid <= '0;
         chk_pc  <= '0;
      end else begin
         chk_v   <= issue_valid && !(redir_valid && redir_wid == issue_wid)
                    && !spawn_sel[issue_wid];
         chk_wid <= issue_wid;
         chk_pc  <= issue_pc;
      end
   end

   AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (active[issue_wid] && !stall[issue_wid]));      // R2
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      chk_v |-> (pc[chk_wid] == chk_pc + STEP));                      // R4
   AST_HOLD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      hold_valid |=> stall[$past(hold_wid)]);                         // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !issue_valid);                                         // R9

   generate
      for (genvar w = 0; w < NW; w++) begin : g_chk
         AST_LIVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            active[w] |-> (tmask[w] != '0));                          // R6
      end
   endgenerate
endmodule

// File: tb/warp_sched_test.sv
`timescale 1ns/1ps
module warp_sched_test;
   localparam logic [31:0] RPC = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_valid = 1'b0;
   logic [1:0]  hold_wid = '0;
   logic [1:0]  ctl_op = '0;
   logic [1:0]  ctl_wid = '0;
   logic [3:0]  ctl_count = '0;
   logic [31:0] ctl_addr = '0;
   logic        ctl_bar = 1'b0;
   logic        redir_valid = 1'b0;
   logic [1:0]  redir_wid = '0;
   logic [31:0] redir_pc = '0;
   logic        issue_valid;
   logic [1:0]  issue_wid;
   logic [31:0] issue_pc;
   logic [3:0]  issue_tmask;
   logic        done;

   warp_sched uut (
      .clk(clk), .rst_n(rst_n),
      .hold_valid(hold_valid), .hold_wid(hold_wid),
      .ctl_op(ctl_op), .ctl_wid(ctl_wid), .ctl_count(ctl_count),
      .ctl_addr(ctl_addr), .ctl_bar(ctl_bar),
      .redir_valid(redir_valid), .redir_wid(redir_wid), .redir_pc(redir_pc),
      .issue_valid(issue_valid), .issue_wid(issue_wid),
      .issue_pc(issue_pc), .issue_tmask(issue_tmask), .done(done)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   int    n_vec = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   string ctx = "R1 reset";

   // reference model state
   logic [3:0]  m_act, m_stl;
   logic [31:0] m_pc [4];
   logic [3:0]  m_tm [4];
   int          m_ptr;
   logic [3:0]  m_bmem [2];
   int          m_bcnt [2];

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s [%s]: actual %0h expected %0h", what, ctx, act, exp);
      end
   endtask

   task automatic clear_in();
      hold_valid = 1'b0; ctl_op = 2'd0; redir_valid = 1'b0;
   endtask

   // one cycle: compare outputs with the model, update the model, clock
   task automatic step();
      logic [3:0] rdy;
      bit         ev;
      int         ew;
      ev = 1'b0; ew = 0;
      rdy = m_act & ~m_stl;
      for (int i = 3; i >= 0; i--) begin
         int idx;
         idx = (m_ptr + i) % 4;
         if (rdy[idx]) begin ev = 1'b1; ew = idx; end
      end
      chk(issue_valid == ev, "R2 issue_valid", 32'(issue_valid), 32'(ev));
      if (ev) begin
         chk(issue_wid == 2'(ew), "R3 issue_wid", 32'(issue_wid), 32'(ew));
         chk(issue_pc == m_pc[ew], "R4 issue_pc", issue_pc, m_pc[ew]);
         chk(issue_tmask == m_tm[ew], "R6 issue_tmask", 32'(issue_tmask), 32'(m_tm[ew]));
      end
      chk(done == (m_act == 4'b0), "R9 done", 32'(done), 32'(m_act == 4'b0));

      if (ev) begin
         m_pc[ew] = m_pc[ew] + 32'd4;
         m_ptr = (ew + 1) % 4;
      end
      if (redir_valid) m_pc[redir_wid] = redir_pc;
      case (ctl_op)
         2'd1: begin
            if (ctl_count == 0) m_act[ctl_wid] = 1'b0;
            else m_tm[ctl_wid] = (ctl_count >= 4) ? 4'hF : 4'((1 << ctl_count) - 1);
            m_stl[ctl_wid] = 1'b0;
         end
         2'd2: begin
            for (int w = 0; w < 4; w++)
               if (w < int'(ctl_count) && w != int'(ctl_wid)) begin
                  m_act[w] = 1'b1; m_stl[w] = 1'b0; m_pc[w] = ctl_addr; m_tm[w] = 4'd1;
               end
            m_stl[ctl_wid] = 1'b0;
         end
         2'd3: begin
            if (m_bcnt[ctl_bar] + 1 >= int'(ctl_count)) begin
               m_stl = m_stl & ~(m_bmem[ctl_bar] | (4'd1 << ctl_wid));
               m_bmem[ctl_bar] = '0; m_bcnt[ctl_bar] = 0;
            end else begin
               m_stl[ctl_wid] = 1'b1;
               m_bmem[ctl_bar] = m_bmem[ctl_bar] | (4'd1 << ctl_wid);
               m_bcnt[ctl_bar]++;
            end
         end
         default: ;
      endcase
      if (hold_valid) m_stl[hold_wid] = 1'b1;

      @(posedge clk); #1;
      clear_in();
   endtask

   task automatic hold(input int w);
      hold_valid = 1'b1; hold_wid = 2'(w); step();
   endtask
   task automatic cmd(input int op, input int w, input int cnt, input logic [31:0] a, input int b);
      ctl_op = 2'(op); ctl_wid = 2'(w); ctl_count = 4'(cnt); ctl_addr = a; ctl_bar = b[0]; step();
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      m_act = 4'b0001; m_stl = '0; m_ptr = 0;
      for (int w = 0; w < 4; w++) begin m_pc[w] = RPC; m_tm[w] = 4'd1; end
      for (int b = 0; b < 2; b++) begin m_bmem[b] = '0; m_bcnt[b] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, then R4 advance and redirect of warp 0
      chk(issue_valid && issue_wid == 2'd0 && issue_pc == RPC && issue_tmask == 4'd1 && !done,
          "R1 reset offer", issue_pc, RPC);
      idle(3);
      ctx = "R4 redirect";
      redir_valid = 1'b1; redir_wid = 2'd0; redir_pc = 32'h100; step();
      idle(2);

      // R5 / R6: hold stalls, thread-mask counts truncate and saturate
      ctx = "R5 R6 tmc";
      hold(0); idle(2);
      cmd(1, 0, 3, 0, 0); idle(2);
      hold(0); cmd(1, 0, 9, 0, 0); idle(1);
      hold(0); cmd(1, 0, 2, 0, 0); idle(1);

      // R7: spawn from warp 0 then partial spawn from warp 3
      ctx = "R7 spawn";
      hold(0); cmd(2, 0, 4, 32'h2000, 0); idle(8);
      hold(3); cmd(2, 3, 2, 32'h3000, 0); idle(8);

      // R3: every non-empty ready pattern
      for (int m = 1; m < 16; m++) begin
         ctx = $sformatf("R3 sweep mask %0h", m);
         for (int w = 0; w < 4; w++) if (!m[w]) hold(w);
         idle(6);
         for (int w = 0; w < 4; w++) if (!m[w]) cmd(1, w, 4, 0, 0);
      end

      // R8: interleaved barriers
      ctx = "R8 barrier";
      cmd(3, 1, 3, 0, 0); idle(2);
      cmd(3, 0, 2, 0, 1); idle(1);
      cmd(3, 2, 3, 0, 0); idle(2);
      cmd(3, 3, 2, 0, 1); idle(2);
      cmd(3, 3, 3, 0, 0); idle(3);
      cmd(3, 2, 0, 0, 1); idle(2);
      cmd(3, 1, 1, 0, 0); idle(2);

      // R9: retire all warps, then revive two
      ctx = "R9 done";
      for (int w = 0; w < 4; w++) cmd(1, w, 0, 0, 0);
      idle(3);
      cmd(2, 0, 3, 32'h4000, 0); idle(4);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule